// File: doc/BRIEF.md
# Floating-Point Compare with Byte Predicate

This unit compares two IEEE-754 binary32 operands under one of four conditions: unordered, equal, greater-than, or greater-or-equal. It returns the result as a predicate byte, all ones when the comparison is true and all zeros when it is false. It also returns an invalid-operation flag. Each operand is classified as a quiet NaN, a signaling NaN, a zero or an ordinary value. Ordering is by signed value, so infinities compare correctly. Positive and negative zero count as equal. A caller that needs less-than or less-or-equal swaps the operands and asks for greater-than or greater-or-equal.

The result is registered, so it appears one clock after the operands and condition are presented. The exponent and mantissa widths are parameters, so the same unit can be built for binary64.

Top module: `fcmp_unit`

## Requirements
- R1: The condition input selects the test: 00 is unordered, 01 is equal, 10 is greater-than and 11 is greater-or-equal. The predicate is 0xFF for true and 0x00 for false, never any other value. It appears on the clock edge after the inputs are sampled and holds until the next edge.
- R2: The unordered test is true when either operand is a NaN, whatever its sign bit. A NaN has an all-ones exponent and a non-zero mantissa.
- R3: The unordered test is false when neither operand is a NaN, including when one operand is an infinity (all-ones exponent, zero mantissa).
- R4: Equal, greater-than and greater-or-equal all return 0x00 whenever either operand is a NaN.
- R5: A signaling NaN is a NaN whose most significant mantissa bit is 0. A signaling NaN in either operand raises the invalid flag under every condition, unordered included. Quiet NaNs (mantissa MSB 1) and non-NaN operands leave the flag low.
- R6: +0 (0x00000000) and -0 (0x80000000) are equal. For that pair, equal is true, greater-than is false and greater-or-equal is true.
- R7: For non-NaN operands, greater-than and greater-or-equal follow signed numeric order. Any positive value is above any negative value, a more negative value is lower, -infinity is below every finite value, and identical values are equal.
- R8: While reset is low the predicate reads 0x00 and the invalid flag reads 0. Reset acts immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | First operand (binary32 by default) |
| b_i | input | 32 | Second operand |
| cond_i | input | 2 | Condition select (00 unordered, 01 equal, 10 greater-than, 11 greater-or-equal) |
| pred_o | output | 8 | Registered predicate byte, 0xFF or 0x00 |
| invalid_o | output | 1 | Registered invalid-operation flag |

## Verification
The bench targets the following corner cases:
- **NaN sign bit.** NaNs with the sign bit set are run under the unordered test. A design that identified NaNs through the sign-extended pattern would report them as ordered.
- **Signaling against quiet NaN.** Signaling and quiet NaNs are paired under every condition. A unit that raised the flag only for ordered tests, or that raised it for quiet NaNs too, gets the flag wrong.
- **Zeros and infinities.** The signed-zero pair and infinity-against-finite cases catch a bitwise equality test and a plain unsigned magnitude compare.
- **Negative operands.** Pairs of negative operands catch a comparator that forgets to reverse the order when both signs are negative.
- **Timing.** One check confirms that the output changes only at the clock edge after the inputs change.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [1:0] {
        CMP_UNORD = 2'b00,
        CMP_EQ    = 2'b01,
        CMP_GT    = 2'b10,
        CMP_GE    = 2'b11
    } cmp_cond_e;

    localparam int PRED_W = 8;
    localparam logic [PRED_W-1:0] PRED_TRUE  = '1;
    localparam logic [PRED_W-1:0] PRED_FALSE = '0;

    typedef struct packed {
        logic [PRED_W-1:0] pred;
        logic              invalid;
    } cmp_res_t;

endpackage

// File: rtl/fcmp_classify.sv
// Decodes one floating-point operand into its class and its sign/magnitude parts.
module fcmp_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] op_i,
    output logic         is_nan_o,
    output logic         is_snan_o,
    output logic         is_zero_o,
    output logic         sign_o,
    output logic [W-2:0] mag_o
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_max;

    always_comb begin
        sign_o    = op_i[W-1];
        mag_o     = op_i[W-2:0];
        exp_f     = op_i[W-2 -: EXP_W];
        man_f     = op_i[MAN_W-1:0];
        exp_max   = &exp_f;
        is_nan_o  = exp_max && (man_f != '0);
        is_snan_o = is_nan_o && !man_f[MAN_W-1];
        is_zero_o = (mag_o == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
// Signed-value ordering of two non-NaN operands held as sign plus magnitude.
module fcmp_order #(
    parameter int MAG_W = 31
) (
    input  logic             a_sign_i,
    input  logic [MAG_W-1:0] a_mag_i,
    input  logic             a_zero_i,
    input  logic             b_sign_i,
    input  logic [MAG_W-1:0] b_mag_i,
    input  logic             b_zero_i,
    output logic             eq_o,
    output logic             gt_o
);
    logic both_zero;

    always_comb begin
        both_zero = a_zero_i && b_zero_i;
        eq_o = both_zero || ((a_sign_i == b_sign_i) && (a_mag_i == b_mag_i));
        if (both_zero) begin
            gt_o = 1'b0;
        end else if (a_sign_i != b_sign_i) begin
            gt_o = !a_sign_i;
        end else if (!a_sign_i) begin
            gt_o = a_mag_i > b_mag_i;
        end else begin
            gt_o = a_mag_i < b_mag_i;
        end
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   cond_i,
    output logic [7:0]   pred_o,
    output logic         invalid_o
);
    import fcmp_pkg::*;

    localparam int NOPS = 2;

    logic [W-1:0] ops      [NOPS];
    logic         op_nan   [NOPS];
    logic         op_snan  [NOPS];
    logic         op_zero  [NOPS];
    logic         op_sign  [NOPS];
    logic [W-2:0] op_mag   [NOPS];

    assign ops[0] = a_i;
    assign ops[1] = b_i;

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .op_i      (ops[gi]),
            .is_nan_o  (op_nan[gi]),
            .is_snan_o (op_snan[gi]),
            .is_zero_o (op_zero[gi]),
            .sign_o    (op_sign[gi]),
            .mag_o     (op_mag[gi])
        );
    end

    logic ord_eq, ord_gt;

    fcmp_order #(.MAG_W(W-1)) u_ord (
        .a_sign_i (op_sign[0]),
        .a_mag_i  (op_mag[0]),
        .a_zero_i (op_zero[0]),
        .b_sign_i (op_sign[1]),
        .b_mag_i  (op_mag[1]),
        .b_zero_i (op_zero[1]),
        .eq_o     (ord_eq),
        .gt_o     (ord_gt)
    );

    cmp_res_t  res_d, res_q;
    cmp_cond_e cond;
    logic      any_nan;
    logic      hit;

    always_comb begin
        cond    = cmp_cond_e'(cond_i);
        any_nan = op_nan[0] || op_nan[1];
        unique case (cond)
            CMP_UNORD: hit = any_nan;
            CMP_EQ:    hit = !any_nan && ord_eq;
            CMP_GT:    hit = !any_nan && ord_gt;
            CMP_GE:    hit = !any_nan && (ord_gt || ord_eq);
            default:   hit = 1'b0;
        endcase
        res_d.pred    = hit ? PRED_TRUE : PRED_FALSE;
        res_d.invalid = op_snan[0] || op_snan[1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '{pred: PRED_FALSE, invalid: 1'b0};
        end else begin
            res_q <= res_d;
        end
    end

    assign pred_o    = res_q.pred;
    assign invalid_o = res_q.invalid;
endmodule

// File: rtl/fcmp_chk.sv
module fcmp_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [1:0]   cond_i,
    input logic [7:0]   pred_o,
    input logic         invalid_o
);
    logic a_nan, b_nan, a_sig, b_sig, both_zero;

    assign a_nan     = (&a_i[W-2:MAN_W]) && (|a_i[MAN_W-1:0]);
    assign b_nan     = (&b_i[W-2:MAN_W]) && (|b_i[MAN_W-1:0]);
    assign a_sig     = a_nan && !a_i[MAN_W-1];
    assign b_sig     = b_nan && !b_i[MAN_W-1];
    assign both_zero = (a_i[W-2:0] == '0) && (b_i[W-2:0] == '0);

    // R1
    pred_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pred_o == 8'hFF) || (pred_o == 8'h00));

    // R2
    unord_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == 2'b00 && (a_nan || b_nan)) |=> (pred_o == 8'hFF));

    // R3
    unord_num_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == 2'b00 && !a_nan && !b_nan) |=> (pred_o == 8'h00));

    // R4
    ord_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i != 2'b00 && (a_nan || b_nan)) |=> (pred_o == 8'h00));

    // R5
    snan_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_sig || b_sig) |=> invalid_o);

    // R5
    no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!a_sig && !b_sig) |=> !invalid_o);

    // R6
    zero_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (both_zero && cond_i == 2'b01) |=> (pred_o == 8'hFF));
endmodule

bind fcmp_unit fcmp_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_i       (a_i),
    .b_i       (b_i),
    .cond_i    (cond_i),
    .pred_o    (pred_o),
    .invalid_o (invalid_o)
);

// File: tb/sim_fcmp_unit.sv
module sim_fcmp_unit;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [1:0]  cond_i = 2'b00;
    logic [7:0]  pred_o;
    logic        invalid_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk_i = ~clk_i;

    fcmp_unit u0 (
        .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
        .cond_i(cond_i), .pred_o(pred_o), .invalid_o(invalid_o)
    );

    localparam logic [31:0] ONE = 32'h3F800000, TWO = 32'h40000000;
    localparam logic [31:0] INF = 32'h7F800000, NINF = 32'hFF800000;
    localparam logic [31:0] QN = 32'h7FC00000, SN = 32'h7FB00000;
    localparam logic [31:0] QNN = 32'hFFC00000, SNN = 32'hFFB00000;
    localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
    localparam logic [31:0] SNEG = 32'hAB98FBA8, BIG = 32'h5AFA572E;
    localparam logic [31:0] M1 = 32'hBF800000, M15 = 32'hBFC00000;

    localparam int NV = 28;
    // columns: a, b, condition, expected predicate, expected flag, requirement
    localparam logic [31:0] VA [NV] = '{
        ONE, INF, QN, QNN, SN, SNN, QN, QN,             // R3 R3 R2 R2 R5 R5 R5 R5
        ONE, ONE, ONE, ONE, ONE, ONE,                   // R4 x6
        PZ, PZ, NZ,                                     // R6 x3
        TWO, ONE, ONE, SNEG, NINF, SNEG, M1, M15,       // R7
        ONE, ONE, INF                                   // R7
    };
    localparam logic [31:0] VB [NV] = '{
        ONE, BIG, BIG, BIG, BIG, BIG, QN, SN,
        QN, SN, QN, SN, QN, SN,
        NZ, NZ, PZ,
        ONE, TWO, SNEG, ONE, SNEG, NINF, M15, M1,
        ONE, ONE, INF
    };
    localparam logic [1:0] VC [NV] = '{
        2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
        2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b11,
        2'b01, 2'b10, 2'b11,
        2'b10, 2'b10, 2'b10, 2'b11, 2'b10, 2'b10, 2'b10, 2'b10,
        2'b11, 2'b10, 2'b01
    };
    localparam logic [7:0] VP [NV] = '{
        8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
        8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
        8'hFF, 8'h00, 8'hFF,
        8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00,
        8'hFF, 8'h00, 8'hFF
    };
    localparam logic VI [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
        1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
        1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0
    };
    localparam int VR [NV] = '{
        3, 3, 2, 2, 5, 5, 5, 5,
        4, 4, 4, 4, 4, 4,
        6, 6, 6,
        7, 7, 7, 7, 7, 7, 7, 7,
        7, 7, 7
    };

    task automatic check_out(input int req, input logic [7:0] ep, input logic ei);
        checks++;
        if (pred_o !== ep || invalid_o !== ei) begin
            errors++;
            $display("FAIL R%0d: pred=%h invalid=%b expected pred=%h invalid=%b",
                     req, pred_o, invalid_o, ep, ei);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [1:0] c);
        a_i = a;
        b_i = b;
        cond_i = c;
    endtask

    initial begin
        #5;
        check_out(8, 8'h00, 1'b0);             // R8 in reset
        drive(QN, SN, 2'b00);
        @(negedge clk_i);
        @(negedge clk_i);
        check_out(8, 8'h00, 1'b0);             // R8 inputs ignored in reset
        rst_ni = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VA[i], VB[i], VC[i]);
            @(negedge clk_i);
            check_out(VR[i], VP[i], VI[i]);
        end

        // R1: output changes only at the edge after inputs change
        drive(ONE, ONE, 2'b01);
        @(negedge clk_i);
        check_out(1, 8'hFF, 1'b0);
        drive(ONE, TWO, 2'b01);
        #1;
        check_out(1, 8'hFF, 1'b0);
        @(negedge clk_i);
        check_out(1, 8'h00, 1'b0);

        // R5: flag under greater-or-equal with signaling NaN on the right
        drive(QN, SNN, 2'b11);
        @(negedge clk_i);
        check_out(5, 8'h00, 1'b1);

        // R8: asynchronous reset clears a true result at once
        drive(SN, SN, 2'b00);
        @(negedge clk_i);
        check_out(2, 8'hFF, 1'b1);
        rst_ni = 1'b0;
        #1;
        check_out(8, 8'h00, 1'b0);
        @(negedge clk_i);
        rst_ni = 1'b1;

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk_i);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule